// File: doc/BRIEF.md
# Split-Access Operand Pattern Trigger

This block watches the completed cycles of a 32-bit processor bus and raises a trigger when one 32-bit operand at a programmed byte address carries a programmed value. Each byte of the pattern can be excluded through a per-byte mask. The operand may sit on any byte offset. When the offset is not zero, the processor moves the operand in two back-to-back bus cycles. The block compares the part carried by the first cycle and holds that result. It decides the whole match on the second cycle.

A trace buffer uses the trace-qualify output to choose which cycles to store. The first cycle of a split operand cannot be qualified when it completes, so it is never marked. A split operand that matches gives exactly one marked record, on its second cycle. An aligned operand is judged and marked on the cycle it arrives. Both outputs are combinational on the presented cycle, so they line up with the cycle they describe.

Top module: `split_pattern_trigger`

## Requirements
- R1: An active-high synchronous reset clears any held partial hit, and both outputs stay low while reset is high. A continuation cycle that follows a reset never matches.
- R2: When the target address has offset 0, one cycle at that address with size code 00 (long) and the first-cycle flag low is judged alone. Match and trace-qualify rise on that same cycle if the data fits the pattern.
- R3: Byte lanes follow big-endian order. Lane n is selected by address bits [1:0] = n, and lane 0 is data[31:24]. Pattern byte value[31:24] belongs to the lowest operand address.
- R4: Size codes are 01 byte, 10 word, 11 three bytes, 00 long. For target offset o (non-zero), the first cycle must be at the target address with size code (4 - o) mod 4. The continuation must be at the next longword address with size code o. Any other size does not count.
- R5: On a first cycle (flag high) only the lanes from offset o to 3 are compared. A fit is held as a pending partial hit. That cycle never raises match or trace-qualify.
- R6: Match and trace-qualify rise on the continuation cycle only when a partial hit is pending and lanes 0 to o-1 also fit. A matching split operand therefore gives one qualified cycle.
- R7: If the first part fits but the second part does not, no match is produced.
- R8: A cycle that carries a fitting second part with no pending partial hit does not match.
- R9: Any valid cycle that is not the continuation drops the pending partial hit. That cycle is then judged on its own, and may start a new partial hit.
- R10: A continuation whose read/write direction differs from the first cycle does not match.
- R11: A mask bit of 0 makes its pattern byte always fit. Mask bit i covers value bits [8i+7:8i].
- R12: Clocks with no valid bus cycle leave a pending partial hit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| busValid | input | 1 | A bus cycle completes this clock |
| busAddr | input | ADDR_W | Byte address of the cycle |
| busSize | input | 2 | Size code (01 byte, 10 word, 11 three bytes, 00 long) |
| busData | input | 32 | Data lanes, lane 0 on bits [31:24] |
| busWrite | input | 1 | 1 = write, 0 = read |
| busFirst | input | 1 | Cycle is the first half of a split operand |
| cmpValue | input | 32 | Operand pattern, most significant byte at the lowest address |
| cmpMask | input | 4 | Per-byte enable, bit i covers cmpValue[8i+7:8i] |
| tgtAddr | input | ADDR_W | Byte address of the watched operand |
| matchPulse | output | 1 | Operand matched on this cycle |
| traceQual | output | 1 | Store this cycle in the trace buffer |

## Verification
The only internal state is the pending partial hit and the direction stored with it. If that state is wrong, the error shows at the ports on the next valid bus cycle. A wrongly held partial hit makes a lone second half match. A lost one makes a good split operand go silent on its continuation. The bench therefore drives pairs, broken pairs, idle gaps, interruptions, direction flips and resets between halves, and compares both outputs on every cycle.

// File: rtl/split_trig_pkg.sv
package split_trig_pkg;
  localparam int LANES = 4;
  localparam int LANE_W = 8;

  localparam logic [1:0] SZ_LONG   = 2'b00;
  localparam logic [1:0] SZ_BYTE   = 2'b01;
  localparam logic [1:0] SZ_WORD   = 2'b10;
  localparam logic [1:0] SZ_TRIPLE = 2'b11;

  // comparison results from the datapath
  typedef struct packed {
    logic tgtHit;        // cycle address equals the target address
    logic nextLongHit;   // cycle address is the longword after the target
    logic firstLanesOk;  // lanes offset..3 fit the pattern
    logic secondLanesOk; // lanes 0..offset-1 fit the pattern
    logic allLanesOk;    // all four lanes fit
    logic dirSame;       // direction equals the held one
    logic pend;          // partial hit held
  } cmpFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPend;
    logic pendVal;
    logic pendDir;
  } ctlStrb_t;
endpackage

// File: rtl/split_trig_dp.sv
module split_trig_dp
  import split_trig_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [LANES*LANE_W-1:0]    busData,
  input  logic                       busWrite,
  input  logic [LANES*LANE_W-1:0]    cmpValue,
  input  logic [LANES-1:0]           cmpMask,
  input  logic [ADDR_W-1:0]          tgtAddr,
  input  ctlStrb_t                   strb,
  output cmpFlags_t                  flags
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int LONG_W = ADDR_W - 2;

  logic [1:0]       tgtOffs;
  logic [LONG_W-1:0] nextLong;
  logic [LANES-1:0] laneEq;
  logic [LANES-1:0] firstNeed;
  logic             pendQ;
  logic             pendDirQ;

  assign tgtOffs  = tgtAddr[1:0];
  assign nextLong = tgtAddr[ADDR_W-1:2] + 1'b1;

  // lane n holds operand byte (n - offset) mod 4
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [1:0]        opIdx;
    logic [LANE_W-1:0] laneData;
    logic [LANE_W-1:0] patByte;
    logic              patEn;
    assign opIdx    = 2'(n) - tgtOffs;
    assign laneData = busData[DATA_W-1-n*LANE_W -: LANE_W];
    assign patByte  = cmpValue[DATA_W-1-int'(opIdx)*LANE_W -: LANE_W];
    assign patEn    = cmpMask[LANES-1-int'(opIdx)];
    assign laneEq[n]    = !patEn || (laneData == patByte);
    assign firstNeed[n] = (2'(n) >= tgtOffs);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ    <= 1'b0;
      pendDirQ <= 1'b0;
    end else if (strb.loadPend) begin
      pendQ    <= strb.pendVal;
      pendDirQ <= strb.pendDir;
    end
  end

  always_comb begin
    flags.tgtHit        = (busAddr == tgtAddr);
    flags.nextLongHit   = (busAddr == {nextLong, 2'b00});
    flags.firstLanesOk  = &(laneEq | ~firstNeed);
    flags.secondLanesOk = &(laneEq | firstNeed);
    flags.allLanesOk    = &laneEq;
    flags.dirSame       = (pendDirQ == busWrite);
    flags.pend          = pendQ;
  end

  AST_PEND_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    strb.loadPend && strb.pendVal |-> flags.tgtHit && flags.firstLanesOk) else $error("pend set off target"); // R5
  AST_IDLE_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
    !strb.loadPend |=> pendQ == $past(pendQ)) else $error("pending changed while idle"); // R12
endmodule

// File: rtl/split_trig_ctl.sv
module split_trig_ctl
  import split_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busValid,
  input  logic [1:0] busSize,
  input  logic       busWrite,
  input  logic       busFirst,
  input  logic [1:0] tgtOffs,
  input  cmpFlags_t  flags,
  output ctlStrb_t   strb,
  output logic       hitOut
);
  logic       offsNz;
  logic [1:0] firstSize;
  logic       firstCand;
  logic       contin;
  logic       splitHit;
  logic       alignHit;

  assign offsNz    = (tgtOffs != 2'd0);
  assign firstSize = 2'd0 - tgtOffs;

  assign firstCand = busValid && busFirst && offsNz && flags.tgtHit &&
                     (busSize == firstSize) && flags.firstLanesOk;

  assign contin = flags.pend && flags.dirSame && flags.nextLongHit &&
                  !busFirst && offsNz && (busSize == tgtOffs);

  assign splitHit = busValid && contin && flags.secondLanesOk;
  assign alignHit = busValid && !offsNz && !busFirst && (busSize == SZ_LONG) &&
                    flags.tgtHit && flags.allLanesOk;

  assign hitOut = !rst && (splitHit || alignHit);

  // every valid cycle rewrites the held state: only a fitting first half keeps one
  always_comb begin
    strb.loadPend = busValid;
    strb.pendVal  = firstCand;
    strb.pendDir  = busWrite;
  end

  AST_FIRST_UNTRACED: assert property (@(posedge clk) disable iff (rst)
    busValid && busFirst |-> !hitOut) else $error("first half qualified"); // R5
  AST_SPLIT_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    hitOut && offsNz |-> flags.pend) else $error("split hit without partial"); // R6
  AST_ALIGNED_SINGLE: assert property (@(posedge clk) disable iff (rst)
    hitOut && !offsNz |-> flags.tgtHit && !busFirst) else $error("aligned hit off target"); // R2
  AST_PEND_DROPPED: assert property (@(posedge clk) disable iff (rst)
    busValid && !busFirst |=> !flags.pend) else $error("partial survived a non-first cycle"); // R9
  AST_ONE_RECORD: assert property (@(posedge clk) disable iff (rst)
    hitOut && offsNz |=> !flags.pend) else $error("partial kept after split hit"); // R6
endmodule

// File: rtl/split_pattern_trigger.sv
module split_pattern_trigger
  import split_trig_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busData,
  input  logic              busWrite,
  input  logic              busFirst,
  input  logic [31:0]       cmpValue,
  input  logic [3:0]        cmpMask,
  input  logic [ADDR_W-1:0] tgtAddr,
  output logic              matchPulse,
  output logic              traceQual
);
  ctlStrb_t  strb;
  cmpFlags_t flags;
  logic      hit;

  split_trig_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busData  (busData),
    .busWrite (busWrite),
    .cmpValue (cmpValue),
    .cmpMask  (cmpMask),
    .tgtAddr  (tgtAddr),
    .strb     (strb),
    .flags    (flags)
  );

  split_trig_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .busValid (busValid),
    .busSize  (busSize),
    .busWrite (busWrite),
    .busFirst (busFirst),
    .tgtOffs  (tgtAddr[1:0]),
    .flags    (flags),
    .strb     (strb),
    .hitOut   (hit)
  );

  assign matchPulse = hit;
  assign traceQual  = hit;
endmodule

// File: tb/split_pattern_trigger_tb.sv
`timescale 1ns/1ps
module split_pattern_trigger_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic [1:0]  busSize = 2'b00;
  logic [31:0] busData = '0;
  logic        busWrite = 1'b0;
  logic        busFirst = 1'b0;
  logic [31:0] cmpValue = 32'hA1B2C3D4;
  logic [3:0]  cmpMask = 4'hF;
  logic [31:0] tgtAddr = 32'h100;
  logic        matchPulse;
  logic        traceQual;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { logic exp; string tag; } expItem_t;
  expItem_t expQ[$];

  split_pattern_trigger #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst(rst), .busValid(busValid), .busAddr(busAddr),
    .busSize(busSize), .busData(busData), .busWrite(busWrite),
    .busFirst(busFirst), .cmpValue(cmpValue), .cmpMask(cmpMask),
    .tgtAddr(tgtAddr), .matchPulse(matchPulse), .traceQual(traceQual)
  );

  always #10 clk = ~clk;

  task automatic busCyc(input logic [31:0] a, input logic [1:0] s,
                        input logic [31:0] d, input logic w, input logic f,
                        input logic e, input string tag);
    @(posedge clk); #1;
    busAddr = a; busSize = s; busData = d; busWrite = w; busFirst = f;
    busValid = 1'b1;
    expQ.push_back('{e, tag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      busValid = 1'b0;
    end
  endtask

  task automatic setCfg(input logic [31:0] t, input logic [31:0] v, input logic [3:0] m);
    idle(1);
    tgtAddr = t; cmpValue = v; cmpMask = m;
  endtask

  // monitor: pop expectation for every valid cycle, compare both outputs
  always @(negedge clk) begin
    if (busValid && !rst && !done) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL unexpected cycle: actual match=%0b expected none", matchPulse);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (matchPulse !== it.exp || traceQual !== it.exp) begin
          fails++;
          $display("FAIL %s: actual match=%0b trace=%0b expected %0b",
                   it.tag, matchPulse, traceQual, it.exp);
        end
      end
    end
  end

  task automatic checkResetLow(input string tag);
    @(negedge clk);
    checks++;
    if (matchPulse !== 1'b0 || traceQual !== 1'b0) begin
      fails++;
      $display("FAIL %s: actual match=%0b trace=%0b expected 0", tag, matchPulse, traceQual);
    end
  endtask

  initial begin
    // R1: reset holds outputs low even with a fitting aligned cycle present
    busAddr = 32'h100; busSize = 2'b00; busData = 32'hA1B2C3D4; busValid = 1'b1;
    checkResetLow("R1 reset with aligned fit");
    @(posedge clk); #1; rst = 1'b0; busValid = 1'b0;

    // aligned target 0x100
    busCyc(32'h100, 2'b00, 32'hA1B2C3D4, 1'b0, 1'b0, 1'b1, "R2 aligned hit");
    busCyc(32'h100, 2'b00, 32'hA1B2C3D5, 1'b0, 1'b0, 1'b0, "R3 lane3 mismatch");
    busCyc(32'h100, 2'b00, 32'hD4C3B2A1, 1'b1, 1'b0, 1'b0, "R3 reversed byte order");
    busCyc(32'h104, 2'b00, 32'hA1B2C3D4, 1'b0, 1'b0, 1'b0, "R2 other address");
    busCyc(32'h100, 2'b01, 32'hA1B2C3D4, 1'b0, 1'b0, 1'b0, "R4 byte size not long");
    setCfg(32'h100, 32'hA1B2C3D4, 4'b1101);
    busCyc(32'h100, 2'b00, 32'hA1B2FFD4, 1'b0, 1'b0, 1'b1, "R11 masked byte ignored");
    busCyc(32'h100, 2'b00, 32'hA1B2FFD5, 1'b0, 1'b0, 1'b0, "R11 unmasked byte checked");

    // offset 3: byte then three bytes
    setCfg(32'h203, 32'hA1B2C3D4, 4'hF);
    busCyc(32'h203, 2'b01, 32'h000000A1, 1'b0, 1'b1, 1'b0, "R5 first half untraced off3");
    busCyc(32'h204, 2'b11, 32'hB2C3D400, 1'b0, 1'b0, 1'b1, "R6 split hit off3");
    busCyc(32'h204, 2'b11, 32'hB2C3D400, 1'b0, 1'b0, 1'b0, "R8 repeat after hit");
    busCyc(32'h203, 2'b01, 32'h000000A1, 1'b1, 1'b1, 1'b0, "R5 first half");
    busCyc(32'h204, 2'b11, 32'hB2C3FF00, 1'b1, 1'b0, 1'b0, "R7 second part wrong");
    busCyc(32'h203, 2'b01, 32'h000000FF, 1'b0, 1'b1, 1'b0, "R5 first part wrong");
    busCyc(32'h204, 2'b11, 32'hB2C3D400, 1'b0, 1'b0, 1'b0, "R8 second only");
    busCyc(32'h203, 2'b10, 32'h000000A1, 1'b0, 1'b1, 1'b0, "R4 wrong first size");
    busCyc(32'h204, 2'b11, 32'hB2C3D400, 1'b0, 1'b0, 1'b0, "R4 no partial after bad size");
    busCyc(32'h203, 2'b01, 32'h000000A1, 1'b0, 1'b1, 1'b0, "R5 first half");
    busCyc(32'h204, 2'b10, 32'hB2C3D400, 1'b0, 1'b0, 1'b0, "R4 wrong second size");
    // interruption
    busCyc(32'h203, 2'b01, 32'h000000A1, 1'b0, 1'b1, 1'b0, "R5 first half");
    busCyc(32'h800, 2'b00, 32'h12345678, 1'b0, 1'b0, 1'b0, "R9 unrelated cycle");
    busCyc(32'h204, 2'b11, 32'hB2C3D400, 1'b0, 1'b0, 1'b0, "R9 dropped partial");
    busCyc(32'h203, 2'b01, 32'h000000A1, 1'b0, 1'b1, 1'b0, "R5 first half");
    busCyc(32'h203, 2'b01, 32'h000000A1, 1'b0, 1'b1, 1'b0, "R9 new first judged alone");
    busCyc(32'h204, 2'b11, 32'hB2C3D400, 1'b0, 1'b0, 1'b1, "R9 restarted split hits");
    // direction change
    busCyc(32'h203, 2'b01, 32'h000000A1, 1'b1, 1'b1, 1'b0, "R5 first half write");
    busCyc(32'h204, 2'b11, 32'hB2C3D400, 1'b0, 1'b0, 1'b0, "R10 direction flipped");
    // idle gap
    busCyc(32'h203, 2'b01, 32'h000000A1, 1'b1, 1'b1, 1'b0, "R5 first half");
    idle(3);
    busCyc(32'h204, 2'b11, 32'hB2C3D400, 1'b1, 1'b0, 1'b1, "R12 hit across idle gap");

    // offset 2: word + word
    setCfg(32'h302, 32'hA1B2C3D4, 4'hF);
    busCyc(32'h302, 2'b10, 32'h0000A1B2, 1'b0, 1'b1, 1'b0, "R5 first half off2");
    busCyc(32'h304, 2'b10, 32'hC3D40000, 1'b0, 1'b0, 1'b1, "R6 split hit off2");
    busCyc(32'h302, 2'b00, 32'hA1B2C3D4, 1'b0, 1'b0, 1'b0, "R2 long at unaligned target");

    // offset 1: three bytes + byte, masked
    setCfg(32'h401, 32'hA1B2C3D4, 4'b0111);
    busCyc(32'h401, 2'b11, 32'h00EEB2C3, 1'b0, 1'b1, 1'b0, "R11 first half masked off1");
    busCyc(32'h404, 2'b01, 32'hD4000000, 1'b0, 1'b0, 1'b1, "R6 split hit off1");

    // reset between halves
    busCyc(32'h401, 2'b11, 32'h00A1B2C3, 1'b0, 1'b1, 1'b0, "R5 first half");
    @(posedge clk); #1;
    busValid = 1'b1; busAddr = 32'h404; busSize = 2'b01; busData = 32'hD4000000;
    busFirst = 1'b0; rst = 1'b1;
    checkResetLow("R1 outputs low in reset");
    @(posedge clk); #1; rst = 1'b0; busValid = 1'b0;
    busCyc(32'h404, 2'b01, 32'hD4000000, 1'b0, 1'b0, 1'b0, "R1 partial cleared by reset");
    idle(2);

    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d items left expected 0", expQ.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule